// File: doc/BRIEF.md
# Streaming Packet Framer With Sequencing

The framer turns a plain stream of 64-bit payload lines into headered data packets for a packet network. Each burst of input lines is cut into packets of a configured size. Every packet starts with a header line that carries the following fields:

- a time-present flag
- an end-of-burst flag
- a 12-bit sequence number
- the packet length in bytes
- source and destination stream IDs

When timing is on, a 64-bit timestamp line follows the header. The block keeps its own sequence counter and its own timestamp, and advances both after every packet.

Software sets up the framer through a small write-only register port. The settings are:

- samples per packet
- bytes per sample
- ticks per sample
- the two stream IDs
- the burst length, with its end-of-burst and time flags
- a starting timestamp

Once the framer is configured, the first valid input line starts a burst. The block sends the header, and the timestamp line if timing is on, while holding the input. It then passes payload lines straight through, with valid/ready handshakes on both sides and tlast on the last line of each packet.

Top module: `pkt_framer`

## Requirements
- R1: Register writes take effect when `cfg_we` is high at a clock edge. The `cfg_addr` map is:
  - 0: samples per packet, taken from the low CNT_W bits of the data.
  - 1: bytes per sample, taken from bits [7:0].
  - 2: ticks per sample, all 32 bits.
  - 3: source stream ID, bits [15:0].
  - 4: destination stream ID, bits [15:0].
  - 5: burst setup. Bits [CNT_W-1:0] hold the burst length in lines, bit 16 requests end-of-burst and bit 17 enables timing.
  - 6: timestamp low word.
  - 7: timestamp high word.
- R2: Each packet of a burst carries lines_per_packet = floor(samples_per_packet × bytes_per_sample / 8) payload lines, except possibly the last.
- R3: A burst of N lines is emitted as ceil(N / lines_per_packet) packets. The last packet holds the remaining lines.
- R4: The header line has the packet type 00 in bits [63:62], has_time in bit 61, eob in bit 60, the sequence number in [59:48], the length in [47:32], the source ID in [31:16] and the destination ID in [15:0].
- R5: The eob bit is 1 only in the last packet of a burst, and only when end-of-burst was requested. It is 0 in every other packet.
- R6: The length field equals 8 × (payload_lines + has_time + 1).
- R7: The sequence number increments by one after every packet, including packets in later bursts, and wraps from 4095 to 0.
- R8: Writing the destination ID clears the sequence counter to 0.
- R9: When timing is enabled, a timestamp line directly follows the header. The timestamp starts at the loaded value and grows by ticks_per_sample × samples_per_packet after every packet.
- R10: When lines_per_packet is 0, `cfg_err` is 1, no output line is emitted and no input line is accepted.
- R11: `m_tlast` is 1 only on the final payload line of a packet. `s_tready` is 0 while the header or timestamp line is offered.
- R12: After reset, `m_tvalid` and `s_tready` are 0, all settings and the sequence counter are 0, and `cfg_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_err | output | 1 | Packet size is zero |
| s_tdata | input | 64 | Input payload line |
| s_tvalid | input | 1 | Input line valid |
| s_tready | output | 1 | Input line accepted |
| m_tdata | output | 64 | Output line (header, timestamp or payload) |
| m_tvalid | output | 1 | Output line valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Last line of a packet |

## Verification
Some rules are checked on every cycle:

- the error state never emits or accepts a line;
- input ready is never given without output ready, and tlast is only offered while the input is being passed through;
- a header or timestamp line held by backpressure stays stable;
- the sequence counter steps by one at each packet end, and a destination write clears it.

Other behaviour only shows in the bench's scenarios:

- the split of bursts into full and short packets;
- the packed header fields;
- the eob placement;
- the timestamp arithmetic across packets and bursts;
- the wrap from 4095 to 0.

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        cfg_err,
  input  logic [63:0] s_tdata,
  input  logic        s_tvalid,
  output logic        s_tready,
  output logic [63:0] m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast
);
  localparam int LPP_W = CNT_W + 5;
  localparam logic [2:0] A_SPP = 3'd0, A_BPS = 3'd1, A_TPS = 3'd2, A_SRC = 3'd3,
                         A_DST = 3'd4, A_BST = 3'd5, A_TLO = 3'd6, A_THI = 3'd7;
  localparam logic [1:0] S_IDLE = 2'd0, S_HDR = 2'd1, S_TS = 2'd2, S_PAY = 2'd3;

  logic [CNT_W-1:0] spp_q, burst_q, remain_q, plen_q, cnt_q;
  logic [7:0]       bps_q;
  logic [31:0]      tps_q;
  logic [15:0]      src_q, dst_q, len_b;
  logic             eob_q, ht_q;
  logic [63:0]      ts_q, hdr;
  logic [11:0]      seq_q;
  logic [1:0]       st;
  logic [LPP_W-1:0] lpp;
  logic             out_fire, last_fire, is_last_pkt;
  logic [CNT_W-1:0] rest;

  function automatic logic [CNT_W-1:0] pick(input logic [CNT_W-1:0] rem, input logic [LPP_W-1:0] l);
    return (LPP_W'(rem) < l) ? rem : CNT_W'(l);
  endfunction

  assign lpp       = LPP_W'(({8'd0, spp_q} * {{CNT_W{1'b0}}, bps_q}) >> 3);
  assign cfg_err   = (lpp == '0);
  assign len_b     = 16'({plen_q + CNT_W'(ht_q) + CNT_W'(1), 3'b000});
  assign is_last_pkt = (remain_q == plen_q);
  assign hdr       = {2'b00, ht_q, eob_q & is_last_pkt, seq_q, len_b, src_q, dst_q};
  assign rest      = remain_q - plen_q;

  assign m_tvalid  = (st == S_HDR) || (st == S_TS) || (st == S_PAY && s_tvalid);
  assign m_tdata   = (st == S_HDR) ? hdr : (st == S_TS) ? ts_q : s_tdata;
  assign s_tready  = (st == S_PAY) && m_tready;
  assign m_tlast   = (st == S_PAY) && (cnt_q == plen_q - CNT_W'(1));
  assign out_fire  = m_tvalid && m_tready;
  assign last_fire = out_fire && m_tlast;

  always_ff @(posedge clk) begin
    if (rst) begin
      spp_q <= '0; bps_q <= '0; tps_q <= '0; src_q <= '0; dst_q <= '0;
      burst_q <= '0; eob_q <= 1'b0; ht_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_SPP: spp_q <= cfg_wdata[CNT_W-1:0];
        A_BPS: bps_q <= cfg_wdata[7:0];
        A_TPS: tps_q <= cfg_wdata;
        A_SRC: src_q <= cfg_wdata[15:0];
        A_DST: dst_q <= cfg_wdata[15:0];
        A_BST: begin
          burst_q <= cfg_wdata[CNT_W-1:0];
          eob_q   <= cfg_wdata[16];
          ht_q    <= cfg_wdata[17];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ts_q <= '0;
    else if (cfg_we && cfg_addr == A_TLO) ts_q[31:0] <= cfg_wdata;
    else if (cfg_we && cfg_addr == A_THI) ts_q[63:32] <= cfg_wdata;
    else if (last_fire) ts_q <= ts_q + 64'(tps_q) * 64'(spp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) seq_q <= '0;
    else if (cfg_we && cfg_addr == A_DST) seq_q <= '0;
    else if (last_fire) seq_q <= seq_q + 12'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; remain_q <= '0; plen_q <= '0; cnt_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (s_tvalid && !cfg_err && burst_q != '0) begin
          remain_q <= burst_q;
          plen_q   <= pick(burst_q, lpp);
          st       <= S_HDR;
        end
        S_HDR: if (m_tready) begin
          cnt_q <= '0;
          st    <= ht_q ? S_TS : S_PAY;
        end
        S_TS: if (m_tready) st <= S_PAY;
        default: if (out_fire) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (m_tlast) begin
            remain_q <= rest;
            plen_q   <= pick(rest, lpp);
            st       <= is_last_pkt ? S_IDLE : S_HDR;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [2:0]  cfg_addr,
  input logic        cfg_err,
  input logic        s_tready,
  input logic [63:0] m_tdata,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic        m_tlast,
  input logic [1:0]  st,
  input logic [11:0] seq_q
);
  logic dst_wr, end_pkt;
  assign dst_wr  = cfg_we && cfg_addr == 3'd4;
  assign end_pkt = m_tvalid && m_tready && m_tlast;

  a_r10_err_silent: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && st == 2'd0) |-> (!m_tvalid && !s_tready));

  a_r11_ready_follows: assert property (@(posedge clk) disable iff (rst)
    s_tready |-> m_tready);

  a_r11_last_in_payload: assert property (@(posedge clk) disable iff (rst)
    (m_tlast && m_tready) |-> s_tready);

  a_r4_hdr_held: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready && (st == 2'd1 || st == 2'd2) && !cfg_we) |=> (m_tvalid && $stable(m_tdata)));

  a_r7_seq_step: assert property (@(posedge clk) disable iff (rst)
    (end_pkt && !dst_wr) |=> (seq_q == $past(seq_q) + 12'd1));

  a_r8_seq_clear: assert property (@(posedge clk) disable iff (rst)
    dst_wr |=> (seq_q == 12'd0));
endmodule

bind pkt_framer pkt_framer_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_err(cfg_err),
  .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
  .m_tlast(m_tlast), .st(st), .seq_q(seq_q)
);

// File: tb/pkt_framer_bench.sv
module pkt_framer_bench;
  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_err;
  logic [63:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [63:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        m_tlast;

  pkt_framer u_pkt_framer (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_d[$];
  bit          exp_l[$];
  string       exp_t[$];

  int unsigned m_spp = 0, m_bps = 0, m_tps = 0;
  logic [15:0] m_src = 0, m_dst = 0;
  logic [11:0] m_seq = 0;
  logic [63:0] m_ts = 0;
  int unsigned pat = 0;
  bit          rnd_ready = 0;
  logic [7:0]  lfsr = 8'h5a;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] line_of(input int unsigned k);
    return {32'hC0DE0000 | k, ~k};
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_tready <= rnd_ready ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst && m_tvalid && m_tready) begin
      if (exp_d.size() == 0) check(0, "R10 unexpected output", m_tdata, 64'd0);
      else begin
        logic [63:0] d; bit l; string t;
        d = exp_d.pop_front(); l = exp_l.pop_front(); t = exp_t.pop_front();
        check(m_tdata == d, t, m_tdata, d);
        check(m_tlast == l, "R11 tlast", 64'(m_tlast), 64'(l));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
    case (a)
      3'd0: m_spp = d[15:0];
      3'd1: m_bps = d[7:0];
      3'd2: m_tps = d;
      3'd3: m_src = d[15:0];
      3'd4: begin m_dst = d[15:0]; m_seq = 0; end
      3'd6: m_ts[31:0] = d;
      3'd7: m_ts[63:32] = d;
      default: ;
    endcase
  endtask

  task automatic burst(input int unsigned n, input bit eob, input bit ht);
    int unsigned lpp, rem, pl, base;
    lpp = m_spp * m_bps / 8;
    wr(3'd5, {14'd0, ht, eob, 16'(n)});
    rem = n; base = pat;
    while (rem > 0) begin
      pl = (rem < lpp) ? rem : lpp;
      exp_d.push_back({2'b00, ht, eob && (rem == pl), m_seq, 16'(8 * (pl + ht + 1)), m_src, m_dst});
      exp_l.push_back(0); exp_t.push_back("R4 R5 R6 R7 header");
      if (ht) begin
        exp_d.push_back(m_ts); exp_l.push_back(0); exp_t.push_back("R9 timestamp");
      end
      for (int unsigned k = 0; k < pl; k++) begin
        exp_d.push_back(line_of(base)); exp_l.push_back(k == pl - 1);
        exp_t.push_back("R2 R3 payload"); base++;
      end
      m_ts += 64'(m_tps) * 64'(m_spp);
      m_seq++;
      rem -= pl;
    end
    for (int unsigned k = 0; k < n; k++) begin
      if (k % 7 == 5) begin @(posedge clk); #1; s_tvalid = 0; end
      @(posedge clk); #1; s_tvalid = 1; s_tdata = line_of(pat); pat++;
      @(negedge clk);
      while (!s_tready) @(negedge clk);
    end
    @(posedge clk); #1; s_tvalid = 0;
    while (exp_d.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst = 0;
    @(negedge clk);
    check(m_tvalid == 0, "R12 m_tvalid", 64'(m_tvalid), 0);
    check(s_tready == 0, "R12 s_tready", 64'(s_tready), 0);
    check(cfg_err == 1, "R12 cfg_err", 64'(cfg_err), 1);

    wr(3'd3, 32'h0000_1230); wr(3'd4, 32'h0000_4561);
    wr(3'd0, 4); wr(3'd1, 4);
    check(cfg_err == 0, "R1 err cleared", 64'(cfg_err), 0);
    burst(5, 1, 0);
    burst(3, 0, 0);

    rnd_ready = 1;
    wr(3'd0, 8); wr(3'd1, 8); wr(3'd2, 3);
    wr(3'd6, 32'h0000_0100); wr(3'd7, 32'h0000_0007);
    burst(20, 0, 1);
    burst(9, 1, 1);
    rnd_ready = 0;

    wr(3'd0, 0);
    check(cfg_err == 1, "R10 err flag", 64'(cfg_err), 1);
    @(posedge clk); #1; s_tvalid = 1; s_tdata = 64'hDEAD;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(s_tready == 0, "R10 no accept", 64'(s_tready), 0);
    end
    @(posedge clk); #1; s_tvalid = 0;

    wr(3'd4, 32'h0000_00A2);
    wr(3'd0, 2); wr(3'd1, 16);
    burst(3, 1, 1);

    wr(3'd0, 1); wr(3'd1, 8);
    burst(4100, 1, 0);
    burst(2, 1, 0);

    check(exp_d.size() == 0, "R3 all packets out", 64'(exp_d.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule